// File: doc/BRIEF.md
# I2C Slave FIFO Event Controller

This block is the data path of a 7-bit-addressed I2C slave. Bytes written by a bus master go into a small receive FIFO, and bytes the master reads come from a transmit FIFO. A local CPU services both FIFOs through single-cycle strobes. The bus lines are open-drain: the block never drives a line high. It only asserts an enable that pulls SCL or SDA low.

Four event flags tell the CPU when service is needed:
- **Command flag.** Marks the first byte of a write transfer while that byte sits at the head of the receive FIFO.
- **Send-request flag.** Raised when the master wants a byte and the transmit FIFO is empty.
- **Transmit low-water flag.** Tracks the transmit fill level against a programmed mark.
- **Receive high-water flag.** Tracks the receive fill level against a programmed mark.

The command and send-request events also stretch SCL, so the master waits until the CPU has read or written one byte. A flush strobe empties the transmit FIFO. Software can use it to discard a filler byte that was written only to release a spurious send request.

Top module: `i2c_fifo_slave`

## Requirements
- R1: After reset:
  - both line enables are low;
  - the command, send-request, receive high-water, overflow and underflow outputs are 0;
  - the transmit low-water flag reads 1 for any mark, because the level is 0.
- R2: The slave pulls SDA low in the ninth clock (ACK) only when the upper seven bits of the address byte equal own_addr. Bit 0 of that byte selects the direction, with 1 meaning a master read. A foreign address is left unacknowledged.
- R3: In a write transfer, each data byte is shifted in MSB first and stored in the receive FIFO in arrival order. It is acknowledged when the FIFO has room. A byte that arrives while the FIFO is full is dropped and left unacknowledged.
- R4: The first data byte after a write address raises irq_cmd while it is the FIFO head. SCL is held low from the end of its ACK until the CPU reads that byte. The read clears irq_cmd and releases SCL. Later bytes of the same transfer never raise irq_cmd.
- R5: In a read transfer, bytes are taken from the transmit FIFO in write order and placed on SDA MSB first.
- R6: When the master requests a byte and the transmit FIFO is empty, irq_send is raised and SCL is held low. A single CPU write clears irq_send and the written byte is sent.
- R7: irq_txlow is 1 exactly when the transmit fill level is less than or equal to lo_mark.
- R8: irq_rxhigh is 1 exactly when the receive fill level is greater than or equal to hi_mark.
- R9: A tx_flush pulse empties the transmit FIFO, discarding every byte written before it.
- R10: FIFO depth is 4 entries in this configuration.
  - A CPU write to the full transmit FIFO is ignored and sets the sticky tx_ovf output.
  - A CPU read of the empty receive FIFO is ignored and sets the sticky rx_udf output.
- R11: A master NACK ends the read transfer. The slave releases SDA and sends nothing more until a new START.
- R12: A STOP (SDA rising while SCL is high) returns the slave to idle. Clocks without a new START are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr | input | 7 | Slave address |
| lo_mark | input | 3 | Transmit low-water mark |
| hi_mark | input | 3 | Receive high-water mark |
| rx_rd | input | 1 | CPU pop strobe for receive FIFO |
| rx_data | output | 8 | Receive FIFO head byte |
| tx_wr | input | 1 | CPU push strobe for transmit FIFO |
| tx_wdata | input | 8 | Byte to push into transmit FIFO |
| tx_flush | input | 1 | Empty the transmit FIFO |
| irq_cmd | output | 1 | Command byte at receive head |
| irq_send | output | 1 | Master waits on empty transmit FIFO |
| irq_txlow | output | 1 | Transmit level at or below mark |
| irq_rxhigh | output | 1 | Receive level at or above mark |
| tx_ovf | output | 1 | Sticky: write to full transmit FIFO |
| rx_udf | output | 1 | Sticky: read of empty receive FIFO |

## Verification
Bus results follow a line change by three clocks: two synchronizer flops and one edge register. The bench's master therefore holds every SDA value for twenty clocks around each SCL edge. It also waits for SCL to really rise before it counts a half period, so stretching is observed rather than assumed.

CPU-side results are due one clock after a strobe. This covers the watermark flags, the clearing of irq_cmd and irq_send, the release of SCL, and the sticky bits. Strobes are driven on the falling clock edge and the outputs are sampled on the next falling edge.

Stretch checks wait 200 clocks after a flag rises, so a short glitch cannot pass for a held line.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    // Bus-side protocol phases of the slave
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,  // not addressed, lines released
        S_ADDR = 3'd1,  // shifting address + direction bit
        S_AACK = 3'd2,  // acknowledging own address
        S_RX   = 3'd3,  // shifting a write data byte
        S_RACK = 3'd4,  // acknowledging a write data byte
        S_TXLD = 3'd5,  // fetching next byte to send (may stretch)
        S_TX   = 3'd6,  // driving a read data byte
        S_TACK = 3'd7   // sampling master ACK/NACK
    } bus_st_e;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_rise,
    output logic sda_fall
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_v, lvl_v, prev_v;

    assign raw_v = {sda_raw, scl_raw};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // STAGES synchronizer flops plus one history flop for edge detection
        logic [STAGES:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-1:0], raw_v[g]};
        end
        assign lvl_v[g]  = chain_q[STAGES-1];
        assign prev_v[g] = chain_q[STAGES];
    end

    assign scl_s    = lvl_v[0];
    assign sda_s    = lvl_v[1];
    assign scl_rise = lvl_v[0] & ~prev_v[0];
    assign scl_fall = ~lvl_v[0] & prev_v[0];
    assign sda_rise = lvl_v[1] & ~prev_v[1];
    assign sda_fall = ~lvl_v[1] & prev_v[1];

endmodule

// File: rtl/i2cs_fifo.sv
// Synchronous FIFO, show-ahead head output. DEPTH must be a power of two.
module i2cs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t fifo_d, fifo_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (fifo_q.lvl == LVL_W'(DEPTH));
    assign empty = (fifo_q.lvl == '0);
    assign level = fifo_q.lvl;
    assign rdata = mem_q[fifo_q.rp];

    always_comb begin
        fifo_d  = fifo_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (flush) begin
            fifo_d = '0;
        end else begin
            if (do_push) fifo_d.wp = fifo_q.wp + PTR_W'(1);
            if (do_pop)  fifo_d.rp = fifo_q.rp + PTR_W'(1);
            fifo_d.lvl = fifo_q.lvl + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[fifo_q.wp] <= wdata;
    end

    // R10: a push into a full FIFO without a pop leaves it full and unchanged
    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == LVL_W'(DEPTH)));

    // R10: a pop from an empty FIFO without a push leaves it empty
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);

endmodule

// File: rtl/i2c_fifo_slave.sv
module i2c_fifo_slave
    import i2cs_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic [6:0]       own_addr,
    input  logic [LVL_W-1:0] lo_mark,
    input  logic [LVL_W-1:0] hi_mark,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    input  logic             tx_wr,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_flush,
    output logic             irq_cmd,
    output logic             irq_send,
    output logic             irq_txlow,
    output logic             irq_rxhigh,
    output logic             tx_ovf,
    output logic             rx_udf
);
    typedef struct packed {
        bus_st_e          st;
        logic [3:0]       cnt;     // bits seen in current byte
        logic [7:0]       sh;      // shift register
        logic             rw;      // 1 = master read
        logic             drv;     // pulling SDA low
        logic             first;   // next received byte is the command
        logic             arm;     // command byte is being acknowledged
        logic             hold;    // stretching SCL for the command byte
        logic             cmd_pend;
        logic [LVL_W-1:0] ahead;   // entries in front of the command byte
        logic             nack;
        logic             tx_ovf;
        logic             rx_udf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
    logic start_det, stop_det;
    logic rx_push, rx_pop, tx_pop;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [LVL_W-1:0] rx_level, tx_level;
    logic [7:0] tx_head;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_rise(sda_rise), .sda_fall(sda_fall)
    );

    i2cs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .flush(1'b0),
        .wdata(ctl_q.sh), .rdata(rx_data), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    i2cs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .pop(tx_pop), .flush(tx_flush),
        .wdata(tx_wdata), .rdata(tx_head), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    assign start_det = sda_fall && scl_s;
    assign stop_det  = sda_rise && scl_s;

    always_comb begin
        ctl_d   = ctl_q;
        rx_push = 1'b0;
        tx_pop  = 1'b0;
        rx_pop  = rx_rd && !rx_empty;

        if (rx_rd && rx_empty) ctl_d.rx_udf = 1'b1;

        // command byte tracking against CPU reads
        if (rx_pop && ctl_q.cmd_pend) begin
            if (ctl_q.ahead == '0) ctl_d.cmd_pend = 1'b0;
            else                   ctl_d.ahead    = ctl_q.ahead - LVL_W'(1);
        end

        if (start_det) begin
            ctl_d.st    = S_ADDR;
            ctl_d.cnt   = '0;
            ctl_d.drv   = 1'b0;
            ctl_d.first = 1'b0;
            ctl_d.arm   = 1'b0;
        end else if (stop_det) begin
            ctl_d.st  = S_IDLE;
            ctl_d.drv = 1'b0;
            ctl_d.arm = 1'b0;
        end else begin
            unique case (ctl_q.st)
                S_IDLE: ;
                S_ADDR: begin
                    if (scl_rise) begin
                        ctl_d.sh  = {ctl_q.sh[6:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        if (ctl_q.sh[7:1] == own_addr) begin
                            ctl_d.rw  = ctl_q.sh[0];
                            ctl_d.drv = 1'b1;
                            ctl_d.st  = S_AACK;
                        end else begin
                            ctl_d.st = S_IDLE;
                        end
                    end
                end
                S_AACK: if (scl_fall) begin
                    ctl_d.drv   = 1'b0;
                    ctl_d.cnt   = '0;
                    ctl_d.st    = ctl_q.rw ? S_TXLD : S_RX;
                    ctl_d.first = !ctl_q.rw;
                end
                S_RX: begin
                    if (scl_rise) begin
                        ctl_d.sh  = {ctl_q.sh[6:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        if (!rx_full) begin
                            rx_push   = 1'b1;
                            ctl_d.drv = 1'b1;
                            if (ctl_q.first) begin
                                ctl_d.cmd_pend = 1'b1;
                                ctl_d.ahead    = rx_level - (rx_pop ? LVL_W'(1) : LVL_W'(0));
                                ctl_d.arm      = 1'b1;
                            end
                        end
                        ctl_d.first = 1'b0;
                        ctl_d.st    = S_RACK;
                    end
                end
                S_RACK: if (scl_fall) begin
                    ctl_d.drv = 1'b0;
                    ctl_d.cnt = '0;
                    ctl_d.st  = S_RX;
                    if (ctl_q.arm && ctl_d.cmd_pend && ctl_d.ahead == '0) ctl_d.hold = 1'b1;
                    ctl_d.arm = 1'b0;
                end
                S_TXLD: if (!tx_empty) begin
                    tx_pop    = 1'b1;
                    ctl_d.sh  = tx_head;
                    ctl_d.drv = !tx_head[7];
                    ctl_d.cnt = '0;
                    ctl_d.st  = S_TX;
                end
                S_TX: begin
                    if (scl_rise) begin
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (ctl_q.cnt == 4'd8) begin
                            ctl_d.drv = 1'b0;
                            ctl_d.st  = S_TACK;
                        end else begin
                            ctl_d.drv = !ctl_q.sh[6];
                            ctl_d.sh  = {ctl_q.sh[6:0], 1'b0};
                        end
                    end
                end
                S_TACK: begin
                    if (scl_rise)      ctl_d.nack = sda_s;
                    else if (scl_fall) ctl_d.st   = ctl_q.nack ? S_IDLE : S_TXLD;
                end
                default: ctl_d.st = S_IDLE;
            endcase
        end

        if (!(ctl_d.cmd_pend && ctl_d.ahead == '0)) ctl_d.hold = 1'b0;
        if (tx_wr && tx_full && !tx_pop) ctl_d.tx_ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_send   = (ctl_q.st == S_TXLD) && tx_empty;
    assign scl_oe     = ctl_q.hold || irq_send;
    assign sda_oe     = ctl_q.drv;
    assign irq_cmd    = ctl_q.cmd_pend && (ctl_q.ahead == '0);
    assign irq_txlow  = (tx_level <= lo_mark);
    assign irq_rxhigh = (rx_level >= hi_mark);
    assign tx_ovf     = ctl_q.tx_ovf;
    assign rx_udf     = ctl_q.rx_udf;

    // R4: a CPU read of the head command byte drops the command flag
    assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmd && rx_rd && !rx_push) |=> !irq_cmd);

    // R4: stretching outside a transmit fetch only happens for a pending command
    assert_hold_needs_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && ctl_q.st != S_TXLD) |-> irq_cmd);

    // R12: after a STOP nothing is driven on SDA and no byte is requested
    assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !irq_send));

endmodule

// File: tb/i2c_fifo_slave_tb_top.sv
module i2c_fifo_slave_tb_top;
    localparam int HALF = 40;
    localparam int QTR  = 20;
    localparam logic [6:0] OWN = 7'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line, scl_oe, sda_oe;
    logic rx_rd = 1'b0, tx_wr = 1'b0, tx_flush = 1'b0;
    logic [7:0] tx_wdata = 8'h00, rx_data;
    logic irq_cmd, irq_send, irq_txlow, irq_rxhigh, tx_ovf, rx_udf;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_fifo_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .lo_mark(3'd1), .hi_mark(3'd3),
        .rx_rd(rx_rd), .rx_data(rx_data), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_flush(tx_flush), .irq_cmd(irq_cmd), .irq_send(irq_send),
        .irq_txlow(irq_txlow), .irq_rxhigh(irq_rxhigh),
        .tx_ovf(tx_ovf), .rx_udf(rx_udf)
    );

    int n_tests = 0, n_fail = 0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_exp[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- bus master driver ----------------
    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; cyc(QTR);
        m_scl_low = 1'b0; wait_scl_high(); cyc(QTR);
        m_sda_low = 1'b1; cyc(HALF);
        m_scl_low = 1'b1; cyc(QTR);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; cyc(QTR);
        m_scl_low = 1'b0; wait_scl_high(); cyc(QTR);
        m_sda_low = 1'b0; cyc(HALF);
    endtask

    task automatic m_bit_out(input logic b);
        m_sda_low = !b; cyc(QTR);
        m_scl_low = 1'b0; wait_scl_high(); cyc(HALF);
        m_scl_low = 1'b1; cyc(QTR);
    endtask

    task automatic m_bit_in(output logic b);
        m_sda_low = 1'b0; cyc(QTR);
        m_scl_low = 1'b0; wait_scl_high(); cyc(HALF / 2);
        b = sda_line; cyc(HALF / 2);
        m_scl_low = 1'b1; cyc(QTR);
    endtask

    task automatic m_write_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
        m_bit_in(ack);
    endtask

    task automatic m_read_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) m_bit_in(d[i]);
        m_bit_out(nack);
    endtask

    // ---------------- CPU driver / scoreboard ----------------
    task automatic cpu_read(input string req);
        logic [7:0] e;
        @(negedge clk);
        e = rx_exp.pop_front();
        chk(req, "receive head byte", rx_data, e);
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic cpu_write_raw(input logic [7:0] d);
        @(negedge clk);
        tx_wdata = d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] d);
        tx_exp.push_back(d);
        cpu_write_raw(d);
    endtask

    task automatic wait_flag(input bit send_not_cmd);
        for (int i = 0; i < 5000; i++) begin
            if (send_not_cmd ? irq_send : irq_cmd) break;
            @(negedge clk);
        end
    endtask

    task automatic m_read_check(input logic nack, input string req);
        logic [7:0] d, e;
        m_read_byte(nack, d);
        e = tx_exp.pop_front();
        chk(req, "byte read by master", d, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic a, a1, a2;
        logic [7:0] d;
        cyc(5); rst_n = 1'b1; cyc(5);

        // R1 reset state
        chk("R1", "scl_oe", scl_oe, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "irq_cmd", irq_cmd, 0);
        chk("R1", "irq_send", irq_send, 0);
        chk("R1", "irq_txlow", irq_txlow, 1);
        chk("R1", "irq_rxhigh", irq_rxhigh, 0);
        chk("R1", "sticky bits", {tx_ovf, rx_udf}, 0);

        // R2 foreign address not acknowledged
        m_start(); m_write_byte({7'h2A, 1'b0}, a);
        chk("R2", "foreign address ack bit", a, 1);
        m_stop();

        // Write transfer: R2, R3, R4, R8
        m_start(); m_write_byte({OWN, 1'b0}, a);
        chk("R2", "own write address ack bit", a, 0);
        rx_exp.push_back(8'hA5); rx_exp.push_back(8'h11);
        fork
            begin
                m_write_byte(8'hA5, a1);
                m_write_byte(8'h11, a2);
            end
            begin
                wait_flag(1'b0);
                chk("R4", "irq_cmd on first byte", irq_cmd, 1);
                cyc(200);
                chk("R4", "scl held for command", {scl_oe, scl_line}, 2'b10);
                cpu_read("R4");
                chk("R4", "irq_cmd after read", irq_cmd, 0);
                chk("R4", "scl released after read", scl_oe, 0);
            end
        join
        chk("R3", "first data ack bit", a1, 0);
        chk("R3", "second data ack bit", a2, 0);
        rx_exp.push_back(8'h22); m_write_byte(8'h22, a);
        rx_exp.push_back(8'h33); m_write_byte(8'h33, a);
        chk("R8", "irq_rxhigh at level 3", irq_rxhigh, 1);
        chk("R4", "no command flag on later bytes", irq_cmd, 0);
        rx_exp.push_back(8'h44); m_write_byte(8'h44, a);
        chk("R3", "fourth byte ack bit", a, 0);
        m_write_byte(8'h55, a);
        chk("R3", "byte into full FIFO ack bit", a, 1);
        m_stop();
        cpu_read("R3");
        chk("R8", "irq_rxhigh at level 3 after read", irq_rxhigh, 1);
        cpu_read("R3");
        chk("R8", "irq_rxhigh at level 2", irq_rxhigh, 0);
        cpu_read("R3"); cpu_read("R3");
        chk("R10", "rx_udf before empty read", rx_udf, 0);
        @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        chk("R10", "rx_udf after empty read", rx_udf, 1);

        // Read transfer: R5, R6, R7, R11
        cpu_write(8'hC3); cpu_write(8'h5A);
        chk("R7", "irq_txlow at level 2", irq_txlow, 0);
        m_start(); m_write_byte({OWN, 1'b1}, a);
        chk("R2", "own read address ack bit", a, 0);
        chk("R7", "irq_txlow at level 1", irq_txlow, 1);
        m_read_check(1'b0, "R5");
        m_read_check(1'b0, "R5");
        fork
            m_read_check(1'b1, "R6");
            begin
                wait_flag(1'b1);
                chk("R6", "irq_send on empty FIFO", irq_send, 1);
                cyc(200);
                chk("R6", "scl held for send request", {scl_oe, scl_line}, 2'b10);
                cpu_write(8'h96);
                chk("R6", "irq_send after write", irq_send, 0);
            end
        join
        cpu_write(8'h00);
        m_read_byte(1'b1, d);
        chk("R11", "bus after master NACK", d, 8'hFF);
        m_stop();

        // R10 overflow: FIFO holds 00, add 01..03, 04 dropped
        cpu_write(8'h01); cpu_write(8'h02); cpu_write(8'h03);
        chk("R10", "tx_ovf before overflow", tx_ovf, 0);
        cpu_write_raw(8'h04);
        chk("R10", "tx_ovf after overflow", tx_ovf, 1);
        m_start(); m_write_byte({OWN, 1'b1}, a);
        for (int i = 0; i < 4; i++) m_read_check(1'b0, "R10");
        fork
            m_read_check(1'b1, "R6");
            begin
                wait_flag(1'b1);
                chk("R10", "dropped byte not sent", irq_send, 1);
                cpu_write(8'h3C);
            end
        join
        m_stop();

        // R9 flush
        cpu_write_raw(8'h77); cpu_write_raw(8'h78);
        chk("R7", "irq_txlow at level 2 again", irq_txlow, 0);
        @(negedge clk); tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
        chk("R9", "irq_txlow after flush", irq_txlow, 1);
        m_start(); m_write_byte({OWN, 1'b1}, a);
        cyc(4);
        chk("R9", "send request after flush", irq_send, 1);
        fork
            m_read_check(1'b1, "R9");
            cpu_write(8'h5C);
        join
        m_stop();

        // R12 STOP returns to idle
        m_start(); m_write_byte({OWN, 1'b0}, a);
        chk("R12", "address ack before stop", a, 0);
        m_stop();
        m_scl_low = 1'b1; cyc(QTR);
        m_write_byte(8'hEE, a);
        chk("R12", "no ack without start", a, 1);
        chk("R12", "nothing stored after stop", irq_rxhigh, 0);
        m_stop();
        cyc(20);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule